// File: doc/BRIEF.md
# Shift, bit and status-flag unit

This block is a single-cycle execution unit for the bit-level part of an 8-bit processor datapath. It rotates a register operand left or right through the carry flag and shifts it right arithmetically. It can exchange the operand's two halves. It copies one operand bit into the status T flag, or T into one bit of the result. It forces any single status bit to one or zero. It also issues a set or clear command for one bit of an external I/O register. The register file, the I/O register file, instruction decode and interrupt logic sit outside the block.

Each cycle the decoder presents an operation code, the register operand, a bit index and the current status byte. At the next rising clock edge the unit registers four outputs: the result with its write-enable, the complete next status byte, and the I/O bit command with its bit index. Each operation changes only its own group of status bits. Every other status bit is passed through unchanged.

Top module: `sbf_unit`

## Requirements
- R1: A synchronous active-high reset clears `res_out`, `res_we`, `stat_out`, `io_cmd` and `io_bit` to zero at the next rising edge.
- R2: Operation codes are 0 idle, 1 rotate-left, 2 rotate-right, 3 arithmetic shift right, 4 half swap, 5 bit store to T, 6 bit load from T, 7 status bit set, 8 status bit clear, 9 I/O bit set, 10 I/O bit clear. All outputs take the values for the inputs sampled at one rising edge, and hold them until the next edge.
- R3: Rotate-left (code 1) gives `{opnd[6:0], C}`, moves the old `opnd[7]` into C and old `opnd[3]` into H, and asserts `res_we`.
- R4: Rotate-right (code 2) gives `{C, opnd[7:1]}`, moves old `opnd[0]` into C and asserts `res_we`.
- R5: Arithmetic shift right (code 3) keeps bit 7, gives `{opnd[7], opnd[7:1]}`, moves old `opnd[0]` into C and asserts `res_we`.
- R6: After codes 1 to 3: Z is 1 exactly when the result is zero, N equals result bit 7, V equals N XOR the new C, and S equals N XOR V. H changes only for code 1. T and I never change.
- R7: Half swap (code 4) gives `{opnd[3:0], opnd[7:4]}`, asserts `res_we` and leaves the status byte unchanged.
- R8: Bit store (code 5) copies `opnd[bit_idx]` into T (status bit 6), changes no other status bit and does not assert `res_we`.
- R9: Bit load (code 6) returns the operand with bit `bit_idx` replaced by T, asserts `res_we` and leaves the status byte unchanged.
- R10: The status bit order is C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7. Code 7 forces status bit `bit_idx` to 1 and code 8 forces it to 0. All other bits are unchanged and `res_we` stays low.
- R11: Codes 9 and 10 drive `io_cmd` to 2'b01 (set) or 2'b10 (clear), with `io_bit` equal to `bit_idx`. The status byte is unchanged and `res_we` stays low. For every other code `io_cmd` is 2'b00 and `io_bit` is 0.
- R12: Code 0 and the unused codes 11 to 15 leave the status byte unchanged and assert neither `res_we` nor `io_cmd`. Whenever `res_we` is low, `res_out` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 4 | Operation code |
| opnd | input | DATA_W | Register operand |
| bit_idx | input | IDX_W | Bit index for bit, flag and I/O operations |
| stat_in | input | 8 | Current status byte |
| res_out | output | DATA_W | Registered result |
| res_we | output | 1 | Result write-enable |
| stat_out | output | 8 | Registered next status byte |
| io_cmd | output | 2 | I/O bit command: 00 none, 01 set, 10 clear |
| io_bit | output | IDX_W | I/O bit index carried with the command |

## Verification
The bench builds the unit with its default width of 8 bits. At that width a complete sweep is small enough to run: every operation code, including the unused ones, against all 256 operands, both carry-in values and all eight bit indices. The sweep compares the whole status byte each time. This shows that bits outside each operation's flag group survive, and that every bit index reaches its status position. A short table of worked vectors and directed reset and latency checks pin down the boundary values.

// File: rtl/sbf_pkg.sv
package sbf_pkg;

    localparam int STAT_W = 8;

    // Status byte bit positions
    localparam int FLG_C = 0;
    localparam int FLG_Z = 1;
    localparam int FLG_N = 2;
    localparam int FLG_V = 3;
    localparam int FLG_S = 4;
    localparam int FLG_H = 5;
    localparam int FLG_T = 6;
    localparam int FLG_I = 7;

    typedef enum logic [3:0] {
        SBF_IDLE   = 4'd0,
        SBF_ROTL   = 4'd1,
        SBF_ROTR   = 4'd2,
        SBF_SHRA   = 4'd3,
        SBF_HSWAP  = 4'd4,
        SBF_TSTORE = 4'd5,
        SBF_TLOAD  = 4'd6,
        SBF_FSET   = 4'd7,
        SBF_FCLR   = 4'd8,
        SBF_IOSET  = 4'd9,
        SBF_IOCLR  = 4'd10
    } sbf_op_e;

    typedef enum logic [1:0] {
        IO_NONE = 2'b00,
        IO_SET  = 2'b01,
        IO_CLR  = 2'b10
    } io_cmd_e;

    // Flags produced by a shift or rotate
    typedef struct packed {
        logic c;
        logic z;
        logic n;
        logic v;
        logic s;
        logic h;
    } shift_flags_t;

    function automatic logic is_shift(sbf_op_e op);
        return (op == SBF_ROTL) || (op == SBF_ROTR) || (op == SBF_SHRA);
    endfunction

    function automatic logic writes_result(sbf_op_e op);
        return is_shift(op) || (op == SBF_HSWAP) || (op == SBF_TLOAD);
    endfunction

endpackage

// File: rtl/sbf_shifter.sv
module sbf_shifter
    import sbf_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int NIB = DATA_W / 2
) (
    input  sbf_op_e             op,
    input  logic [DATA_W-1:0]   a,
    input  logic                cin,
    output logic [DATA_W-1:0]   res,
    output logic                cout,
    output logic                hout
);

    // Rotate-left behaves as a + a + cin: the carry out of the low
    // half is the old bit at the top of that half.
    assign hout = a[NIB-1];

    always_comb begin
        res  = a;
        cout = cin;
        case (op)
            SBF_ROTL: begin
                res  = {a[DATA_W-2:0], cin};
                cout = a[DATA_W-1];
            end
            SBF_ROTR: begin
                res  = {cin, a[DATA_W-1:1]};
                cout = a[0];
            end
            SBF_SHRA: begin
                res  = {a[DATA_W-1], a[DATA_W-1:1]};
                cout = a[0];
            end
            SBF_HSWAP: begin
                res  = {a[NIB-1:0], a[DATA_W-1:NIB]};
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sbf_bitxfer.sv
module sbf_bitxfer
    import sbf_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  sbf_op_e             op,
    input  logic [DATA_W-1:0]   a,
    input  logic [IDX_W-1:0]    idx,
    input  logic                tin,
    output logic [DATA_W-1:0]   ld_res,
    output logic                picked,
    output io_cmd_e             io_cmd,
    output logic [IDX_W-1:0]    io_idx
);

    logic [DATA_W-1:0] sel_hot;

    // One lane per bit: decode the index and splice T into that lane
    for (genvar i = 0; i < DATA_W; i++) begin : g_lane
        assign sel_hot[i] = (idx == IDX_W'(i));
        assign ld_res[i]  = sel_hot[i] ? tin : a[i];
    end

    assign picked = |(a & sel_hot);

    always_comb begin
        io_cmd = IO_NONE;
        io_idx = '0;
        case (op)
            SBF_IOSET: begin
                io_cmd = IO_SET;
                io_idx = idx;
            end
            SBF_IOCLR: begin
                io_cmd = IO_CLR;
                io_idx = idx;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sbf_flagcalc.sv
module sbf_flagcalc
    import sbf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  sbf_op_e             op,
    input  logic [STAT_W-1:0]   stat_in,
    input  logic [DATA_W-1:0]   res,
    input  logic                cout,
    input  logic                hout,
    input  logic                tpick,
    input  logic [2:0]          fidx,
    output logic [STAT_W-1:0]   stat_next
);

    shift_flags_t sf;

    always_comb begin
        sf.c = cout;
        sf.z = (res == '0);
        sf.n = res[DATA_W-1];
        sf.v = sf.n ^ sf.c;
        sf.s = sf.n ^ sf.v;
        sf.h = hout;
    end

    always_comb begin
        stat_next = stat_in;
        if (is_shift(op)) begin
            stat_next[FLG_C] = sf.c;
            stat_next[FLG_Z] = sf.z;
            stat_next[FLG_N] = sf.n;
            stat_next[FLG_V] = sf.v;
            stat_next[FLG_S] = sf.s;
            if (op == SBF_ROTL) begin
                stat_next[FLG_H] = sf.h;
            end
        end
        case (op)
            SBF_TSTORE: stat_next[FLG_T] = tpick;
            SBF_FSET:   stat_next[fidx]  = 1'b1;
            SBF_FCLR:   stat_next[fidx]  = 1'b0;
            default: ;
        endcase
    end

endmodule

// File: rtl/sbf_unit.sv
module sbf_unit
    import sbf_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [3:0]          op_sel,
    input  logic [DATA_W-1:0]   opnd,
    input  logic [IDX_W-1:0]    bit_idx,
    input  logic [STAT_W-1:0]   stat_in,
    output logic [DATA_W-1:0]   res_out,
    output logic                res_we,
    output logic [STAT_W-1:0]   stat_out,
    output logic [1:0]          io_cmd,
    output logic [IDX_W-1:0]    io_bit
);

    sbf_op_e            op;
    logic [DATA_W-1:0]  sh_res;
    logic               sh_cout;
    logic               sh_hout;
    logic [DATA_W-1:0]  ld_res;
    logic               t_pick;
    io_cmd_e            io_cmd_d;
    logic [IDX_W-1:0]   io_idx_d;
    logic [STAT_W-1:0]  stat_d;
    logic [DATA_W-1:0]  res_d;
    logic               we_d;
    logic               live_q;

    assign op = sbf_op_e'(op_sel);

    sbf_shifter #(.DATA_W(DATA_W)) u_shifter (
        .op   (op),
        .a    (opnd),
        .cin  (stat_in[FLG_C]),
        .res  (sh_res),
        .cout (sh_cout),
        .hout (sh_hout)
    );

    sbf_bitxfer #(.DATA_W(DATA_W)) u_bitxfer (
        .op     (op),
        .a      (opnd),
        .idx    (bit_idx),
        .tin    (stat_in[FLG_T]),
        .ld_res (ld_res),
        .picked (t_pick),
        .io_cmd (io_cmd_d),
        .io_idx (io_idx_d)
    );

    sbf_flagcalc #(.DATA_W(DATA_W)) u_flagcalc (
        .op        (op),
        .stat_in   (stat_in),
        .res       (sh_res),
        .cout      (sh_cout),
        .hout      (sh_hout),
        .tpick     (t_pick),
        .fidx      (bit_idx[2:0]),
        .stat_next (stat_d)
    );

    always_comb begin
        we_d  = writes_result(op);
        res_d = '0;
        if (op == SBF_TLOAD) begin
            res_d = ld_res;
        end else if (we_d) begin
            res_d = sh_res;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_out  <= '0;
            res_we   <= 1'b0;
            stat_out <= '0;
            io_cmd   <= IO_NONE;
            io_bit   <= '0;
            live_q   <= 1'b0;
        end else begin
            res_out  <= res_d;
            res_we   <= we_d;
            stat_out <= stat_d;
            io_cmd   <= io_cmd_d;
            io_bit   <= io_idx_d;
            live_q   <= 1'b1;
        end
    end

    // live_q marks that the previous edge was outside reset
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!res_we && io_cmd == IO_NONE && stat_out == '0 && res_out == '0)); // R1
    AST_ROTL_CARRY_IN: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(op_sel) == 4'(SBF_ROTL)) |->
        (stat_out[FLG_C] == $past(opnd[DATA_W-1]) && res_out[0] == $past(stat_in[FLG_C]))); // R3
    AST_ROTR_CARRY_IN: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(op_sel) == 4'(SBF_ROTR)) |->
        (stat_out[FLG_C] == $past(opnd[0]) && res_out[DATA_W-1] == $past(stat_in[FLG_C]))); // R4
    AST_SHRA_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(op_sel) == 4'(SBF_SHRA)) |->
        (res_out[DATA_W-1] == $past(opnd[DATA_W-1]) && res_we)); // R5
    AST_SHIFT_OVF_RULE: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(op_sel) >= 4'(SBF_ROTL) && $past(op_sel) <= 4'(SBF_SHRA)) |->
        (stat_out[FLG_V] == (stat_out[FLG_N] ^ stat_out[FLG_C])
         && stat_out[FLG_T] == $past(stat_in[FLG_T])
         && stat_out[FLG_I] == $past(stat_in[FLG_I]))); // R6
    AST_SWAP_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(op_sel) == 4'(SBF_HSWAP)) |-> (stat_out == $past(stat_in))); // R7
    AST_TSTORE_ONLY_T: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(op_sel) == 4'(SBF_TSTORE)) |->
        (((stat_out ^ $past(stat_in)) & ~(8'h1 << FLG_T)) == '0 && !res_we)); // R8
    AST_FSET_FORCES_BIT: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(op_sel) == 4'(SBF_FSET)) |->
        (stat_out == ($past(stat_in) | (8'h1 << $past(bit_idx[2:0]))))); // R10
    AST_IO_ONE_COMMAND: assert property (@(posedge clk) disable iff (rst)
        $onehot0(io_cmd)); // R11
    AST_NOWRITE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !res_we |-> (res_out == '0)); // R12

endmodule

// File: tb/sbf_unit_bench.sv
module sbf_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op_sel = 4'd1;
    logic [7:0] opnd = 8'hFF;
    logic [2:0] bit_idx = 3'd7;
    logic [7:0] stat_in = 8'hFF;
    logic [7:0] res_out;
    logic       res_we;
    logic [7:0] stat_out;
    logic [1:0] io_cmd;
    logic [2:0] io_bit;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbf_unit u_sbf_unit (
        .clk      (clk),
        .rst      (rst),
        .op_sel   (op_sel),
        .opnd     (opnd),
        .bit_idx  (bit_idx),
        .stat_in  (stat_in),
        .res_out  (res_out),
        .res_we   (res_we),
        .stat_out (stat_out),
        .io_cmd   (io_cmd),
        .io_bit   (io_bit)
    );

    // Worked vectors: op, operand, index, status in | result, we, status out, io cmd, io bit
    typedef struct packed {
        logic [3:0] op;
        logic [7:0] a;
        logic [2:0] idx;
        logic [7:0] st;
        logic [7:0] res;
        logic       we;
        logic [7:0] stn;
        logic [1:0] io;
        logic [2:0] iob;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        '{4'd1,  8'h80, 3'd0, 8'h00, 8'h00, 1'b1, 8'h1B, 2'b00, 3'd0}, // R3 R6 zero result, carry out
        '{4'd1,  8'h08, 3'd0, 8'h01, 8'h11, 1'b1, 8'h20, 2'b00, 3'd0}, // R3 half carry from bit 3
        '{4'd2,  8'h01, 3'd0, 8'h01, 8'h80, 1'b1, 8'h15, 2'b00, 3'd0}, // R4 carry into bit 7
        '{4'd2,  8'h01, 3'd0, 8'h20, 8'h00, 1'b1, 8'h3B, 2'b00, 3'd0}, // R4 R6 H untouched
        '{4'd3,  8'h81, 3'd0, 8'hC0, 8'hC0, 1'b1, 8'hD5, 2'b00, 3'd0}, // R5 sign kept
        '{4'd3,  8'h7E, 3'd0, 8'hFF, 8'h3F, 1'b1, 8'hE0, 2'b00, 3'd0}, // R5 R6 flags cleared
        '{4'd4,  8'hA5, 3'd0, 8'h5A, 8'h5A, 1'b1, 8'h5A, 2'b00, 3'd0}, // R7
        '{4'd5,  8'h10, 3'd4, 8'h00, 8'h00, 1'b0, 8'h40, 2'b00, 3'd0}, // R8 T set
        '{4'd5,  8'hEF, 3'd4, 8'hFF, 8'h00, 1'b0, 8'hBF, 2'b00, 3'd0}, // R8 T cleared
        '{4'd6,  8'h00, 3'd7, 8'h40, 8'h80, 1'b1, 8'h40, 2'b00, 3'd0}, // R9 top bit
        '{4'd6,  8'hFF, 3'd0, 8'hBF, 8'hFE, 1'b1, 8'hBF, 2'b00, 3'd0}, // R9 bottom bit
        '{4'd7,  8'h00, 3'd7, 8'h00, 8'h00, 1'b0, 8'h80, 2'b00, 3'd0}, // R10 set I
        '{4'd8,  8'hFF, 3'd1, 8'hFF, 8'h00, 1'b0, 8'hFD, 2'b00, 3'd0}, // R10 clear Z
        '{4'd9,  8'h00, 3'd5, 8'h3C, 8'h00, 1'b0, 8'h3C, 2'b01, 3'd5}, // R11 set
        '{4'd10, 8'hFF, 3'd2, 8'h3C, 8'h00, 1'b0, 8'h3C, 2'b10, 3'd2}, // R11 clear
        '{4'd15, 8'h55, 3'd3, 8'h99, 8'h00, 1'b0, 8'h99, 2'b00, 3'd0}  // R12 unused code
    };

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd1:       return "R3";
            4'd2:       return "R4";
            4'd3:       return "R5";
            4'd4:       return "R7";
            4'd5:       return "R8";
            4'd6:       return "R9";
            4'd7, 4'd8: return "R10";
            4'd9, 4'd10: return "R11";
            default:    return "R12";
        endcase
    endfunction

    // Reference model: outputs packed as {res, we, status, io, iobit}
    function automatic logic [21:0] model(input logic [3:0] op, input logic [7:0] a,
                                          input logic [2:0] idx, input logic [7:0] st);
        logic [7:0] r;
        logic       w;
        logic [7:0] s;
        logic [1:0] io;
        logic [2:0] iob;
        logic [8:0] sum;
        logic [8:0] wide;
        logic       c;
        logic       n;
        r = 8'h00; w = 1'b0; s = st; io = 2'b00; iob = 3'd0; c = st[0];
        case (op)
            4'd1: begin
                sum = {1'b0, a} + {1'b0, a} + {8'h00, st[0]};
                r = sum[7:0]; c = sum[8]; w = 1'b1;
                s[5] = ((a[3:0] + a[3:0] + {3'b000, st[0]}) > 5'd15);
            end
            4'd2: begin
                wide = {st[0], a};
                r = wide[8:1]; c = wide[0]; w = 1'b1;
            end
            4'd3: begin
                r = $unsigned($signed(a) >>> 1); c = a[0]; w = 1'b1;
            end
            4'd4: begin
                r = (a << 4) | (a >> 4); w = 1'b1;
            end
            4'd5: s[6] = a[idx];
            4'd6: begin
                r = a; r[idx] = st[6]; w = 1'b1;
            end
            4'd7: s = st | (8'h01 << idx);
            4'd8: s = st & ~(8'h01 << idx);
            4'd9: begin io = 2'b01; iob = idx; end
            4'd10: begin io = 2'b10; iob = idx; end
            default: ;
        endcase
        if (op >= 4'd1 && op <= 4'd3) begin
            n = r[7];
            s[0] = c;
            s[1] = (r == 8'h00);
            s[2] = n;
            s[3] = n ^ c;
            s[4] = n ^ (n ^ c);
        end
        return {r, w, s, io, iob};
    endfunction

    task automatic check(input string req, input logic [21:0] act, input logic [21:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual res=%h we=%b stat=%h io=%b bit=%0d expected res=%h we=%b stat=%h io=%b bit=%0d",
                     req, act[21:14], act[13], act[12:5], act[4:3], act[2:0],
                     exp[21:14], exp[13], exp[12:5], exp[4:3], exp[2:0]);
        end
    endtask

    function automatic logic [21:0] outs();
        return {res_out, res_we, stat_out, io_cmd, io_bit};
    endfunction

    task automatic apply(input logic [3:0] op, input logic [7:0] a,
                         input logic [2:0] idx, input logic [7:0] st);
        @(negedge clk);
        op_sel = op; opnd = a; bit_idx = idx; stat_in = st;
        @(posedge clk);
        #1;
    endtask

    initial begin
        // R1: reset with busy inputs
        repeat (2) @(posedge clk);
        #1;
        check("R1", outs(), 22'h0);

        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i].op, VECS[i].a, VECS[i].idx, VECS[i].st);
            check(req_of(VECS[i].op), outs(),
                  {VECS[i].res, VECS[i].we, VECS[i].stn, VECS[i].io, VECS[i].iob});
        end

        // R2: outputs hold between edges and change only at the next edge
        apply(4'd4, 8'hA5, 3'd0, 8'h00);
        @(negedge clk);
        op_sel = 4'd4; opnd = 8'h3C; bit_idx = 3'd0; stat_in = 8'h00;
        #1;
        check("R2", outs(), {8'h5A, 1'b1, 8'h00, 2'b00, 3'd0});
        @(posedge clk);
        #1;
        check("R2", outs(), {8'hC3, 1'b1, 8'h00, 2'b00, 3'd0});

        // R12: idle code
        apply(4'd0, 8'hFF, 3'd6, 8'h6E);
        check("R12", outs(), {8'h00, 1'b0, 8'h6E, 2'b00, 3'd0});

        // Full sweep of every code, operand, carry and index (R3..R12, R6 flags)
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int cin = 0; cin < 2; cin++) begin
                    for (int idx = 0; idx < 8; idx++) begin
                        logic [7:0] st;
                        st = {3'(idx), 4'(a) ^ 4'hA, 1'(cin)};
                        apply(4'(op), 8'(a), 3'(idx), st);
                        check(req_of(4'(op)), outs(), model(4'(op), 8'(a), 3'(idx), st));
                    end
                end
            end
        end

        // R1: reset in mid-run clears outputs
        @(negedge clk);
        rst = 1'b1;
        op_sel = 4'd9; opnd = 8'hFF; bit_idx = 3'd3; stat_in = 8'hFF;
        @(posedge clk);
        #1;
        check("R1", outs(), 22'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule